// File: doc/BRIEF.md
# Multi-Master I2C Arbitration Guard with Clock Synchronisation and Stuck-Bus Recovery

This unit sits beside one master on a shared open-drain two-wire bus. It generates the master's clock, and it watches the data line whenever the clock is high. The clock generator follows the wired-AND rule: it releases SCL after a fixed number of cycles. It then waits until SCL actually reads high before it times the high phase. When another device pulls SCL low early, the unit starts its own low phase at once. As a result the effective clock period is set by the slowest device on the bus.

The guard compares the level the master means to send with the sampled SDA level when SCL is first seen high in each clock period. If the master released the line (a one) but the line is low, another master has won the bit. The guard raises a sticky loss flag and releases both lines. The flag holds until a new start condition appears on the bus.

When the master's clock is disabled and SDA stays low while SCL is high for a programmable time, the unit assumes a device is stuck. A recovery sequencer then toggles SCL up to a fixed number of times, nine by default, and checks SDA on every high phase. As soon as SDA reads high, it ends with a stop condition. If SDA is still low after the last pulse, it raises a failure flag. Byte framing and addressing belong to the master and are not handled here.

Top module: `i2c_arb_guard`

## Requirements
- R1: With clock enabled and no other device disturbing SCL, the unit pulls SCL low for LOW_CYC consecutive cycles and then leaves it released for HIGH_CYC+1 cycles, repeating.
- R2: If another device holds SCL low after the local low phase, the unit keeps SCL released and does not pull it again until HIGH_CYC cycles after the first clock edge at which SCL reads high.
- R3: If another device pulls SCL low during the local high phase, the unit starts pulling SCL low from the next cycle and holds it for LOW_CYC cycles.
- R4: The bit comparison happens at the clock edge at which SCL is first seen high in a period. If tx_active is 1, tx_bit is 1 and SDA reads 0 there, arb_lost is 1 from the next cycle. A tx_bit of 0, or a tx_active of 0, never causes a loss.
- R5: While arb_lost is 1 and no recovery runs, neither scl_pull nor sda_pull is asserted, whatever clk_en, tx_active and tx_bit do.
- R6: arb_lost stays set through bus activity, including a stop condition (SDA rising while SCL is high). It clears one cycle after a start condition: SDA read falling between two consecutive samples while SCL reads high in both.
- R7: With clk_en at 0, recovery (recov_busy = 1) begins after STUCK_CYC consecutive cycles of SDA low with SCL high. A single cycle of SDA high restarts the count. With clk_en at 1, recovery never begins.
- R8: During recovery the unit pulses SCL, samples SDA once per high phase, and never drives SDA until SDA reads high. It then stops pulsing.
- R9: After SDA reads high in recovery, the unit pulls SCL low. While SCL is low it pulls SDA low, then releases SCL, then releases SDA with SCL high. This is a stop condition on the bus, and recov_busy falls in the same cycle SDA is released.
- R10: If SDA is still low at the high phase of pulse number PULSES, recov_fail becomes 1 and recov_busy 0. Both lines stay released and recov_fail stays 1 until reset, even with clk_en at 1.
- R11: After reset, scl_pull, sda_pull, arb_lost, recov_busy and recov_fail are all 0.
- R12: While transmitting and not lost, sda_pull equals the inverse of tx_bit in the same cycle. It is 0 when tx_active is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Master requests the bus clock to run |
| tx_active | input | 1 | Master is currently sending bits on SDA |
| tx_bit | input | 1 | Level the master intends on SDA (1 = release) |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| recov_busy | output | 1 | Stuck-bus recovery in progress |
| recov_fail | output | 1 | Recovery ran out of pulses with SDA still low |

## Verification
The bench builds the unit with LOW_CYC = 4, HIGH_CYC = 4, PULSES = 9 and STUCK_CYC = 8 instead of the long production defaults. With these values a full nine-pulse exhaustion, a recovery that succeeds early, and a stuck-detection window with an interruption each take only tens of cycles. The short phases also let the bench place a foreign SCL pull at an exact cycle inside a low or high phase. This exercises both stretching and early-low synchronisation at phase boundaries. Two wired-AND lines are modelled in the bench, so each foreign pull combines with the unit's own drives the way the real bus would.

// File: rtl/i2c_guard_pkg.sv
package i2c_guard_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAIT,
    PH_HIGH
  } pace_ph_t;

  typedef enum logic [2:0] {
    RC_IDLE,
    RC_PULSE,
    RC_STOP_LOW,
    RC_STOP_HIGH,
    RC_FAIL
  } recov_st_t;

  // SDA falls while SCL stays high across two samples
  function automatic logic start_edge(input logic scl_prev, input logic sda_prev,
                                      input logic scl_now, input logic sda_now);
    return scl_prev && scl_now && sda_prev && !sda_now;
  endfunction

  // the bit this master loses: it released SDA yet the line reads low
  function automatic logic bit_lost(input logic sending, input logic intended,
                                    input logic line);
    return sending && intended && !line;
  endfunction

  // the condition that looks like a device holding SDA down
  function automatic logic looks_stuck(input logic idle, input logic scl,
                                       input logic sda);
    return idle && scl && !sda;
  endfunction

endpackage

// File: rtl/i2c_scl_pacer.sv
module i2c_scl_pacer
  import i2c_guard_pkg::*;
#(
  parameter int LOW_CYC  = 250,
  parameter int HIGH_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic scl_in,
  output logic scl_pull,
  output logic sample_stb
);
  localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  pace_ph_t       ph;
  logic [CW-1:0]  cnt;

  // first edge at which the released line is seen high
  assign sample_stb = run && (ph == PH_WAIT) && scl_in;
  assign scl_pull   = (ph == PH_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (!run) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          ph  <= PH_LOW;
          cnt <= '0;
        end
        PH_LOW: begin
          if (cnt == CW'(LOW_CYC - 1)) begin
            ph  <= PH_WAIT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_WAIT: begin
          if (scl_in) begin
            ph  <= PH_HIGH;
            cnt <= '0;
          end
        end
        PH_HIGH: begin
          if (!scl_in || cnt == CW'(HIGH_CYC - 1)) begin
            ph  <= PH_LOW;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          ph  <= PH_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_arb_watch.sv
module i2c_arb_watch
  import i2c_guard_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_stb,
  input  logic tx_active,
  input  logic tx_bit,
  input  logic scl_in,
  input  logic sda_in,
  output logic arb_lost,
  output logic loss_evt,
  output logic start_seen
);
  logic scl_q;
  logic sda_q;

  assign start_seen = start_edge(scl_q, sda_q, scl_in, sda_in);
  assign loss_evt   = sample_stb && bit_lost(tx_active, tx_bit, sda_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      arb_lost <= 1'b0;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
      if (loss_evt) begin
        arb_lost <= 1'b1;
      end else if (start_seen) begin
        arb_lost <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import i2c_guard_pkg::*;
#(
  parameter int LOW_CYC   = 250,
  parameter int HIGH_CYC  = 250,
  parameter int PULSES    = 9,
  parameter int STUCK_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_idle,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sample_stb,
  output logic run_pulses,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic fail
);
  localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int SW   = $clog2(STUCK_CYC + 1);
  localparam int PW   = $clog2(PULSES + 1);

  recov_st_t      st;
  logic [SW-1:0]  stuck_cnt;
  logic [PW-1:0]  pulse_cnt;
  logic [CW-1:0]  ph_cnt;
  logic           stuck_now;

  assign stuck_now  = looks_stuck(master_idle, scl_in, sda_in);
  assign run_pulses = (st == RC_PULSE);
  assign scl_pull   = (st == RC_STOP_LOW);
  assign sda_pull   = ((st == RC_STOP_LOW) && (ph_cnt != '0)) || (st == RC_STOP_HIGH);
  assign busy       = (st == RC_PULSE) || (st == RC_STOP_LOW) || (st == RC_STOP_HIGH);
  assign fail       = (st == RC_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RC_IDLE;
      stuck_cnt <= '0;
      pulse_cnt <= '0;
      ph_cnt    <= '0;
    end else begin
      case (st)
        RC_IDLE: begin
          if (stuck_now) begin
            if (stuck_cnt == SW'(STUCK_CYC - 1)) begin
              st        <= RC_PULSE;
              stuck_cnt <= '0;
              pulse_cnt <= '0;
            end else begin
              stuck_cnt <= stuck_cnt + 1'b1;
            end
          end else begin
            stuck_cnt <= '0;
          end
        end
        RC_PULSE: begin
          if (sample_stb) begin
            if (sda_in) begin
              st     <= RC_STOP_LOW;
              ph_cnt <= '0;
            end else if (pulse_cnt == PW'(PULSES - 1)) begin
              st <= RC_FAIL;
            end else begin
              pulse_cnt <= pulse_cnt + 1'b1;
            end
          end
        end
        RC_STOP_LOW: begin
          if (ph_cnt == CW'(LOW_CYC - 1)) begin
            st     <= RC_STOP_HIGH;
            ph_cnt <= '0;
          end else begin
            ph_cnt <= ph_cnt + 1'b1;
          end
        end
        RC_STOP_HIGH: begin
          if (scl_in) begin
            if (ph_cnt == CW'(HIGH_CYC - 1)) begin
              st     <= RC_IDLE;
              ph_cnt <= '0;
            end else begin
              ph_cnt <= ph_cnt + 1'b1;
            end
          end
        end
        RC_FAIL: st <= RC_FAIL;
        default: st <= RC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_arb_guard.sv
module i2c_arb_guard
  import i2c_guard_pkg::*;
#(
  parameter int LOW_CYC   = 250,
  parameter int HIGH_CYC  = 250,
  parameter int PULSES    = 9,
  parameter int STUCK_CYC = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic tx_active,
  input  logic tx_bit,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic arb_lost,
  output logic recov_busy,
  output logic recov_fail
);
  // internal events, named for the bound checker
  logic pace_run;
  logic pace_pull;
  logic sample_stb;
  logic loss_evt;
  logic start_seen;
  logic rec_run;
  logic rec_scl_pull;
  logic rec_sda_pull;
  logic rec_engaged;
  logic master_sda_pull;

  assign rec_engaged     = recov_busy || recov_fail;
  assign pace_run        = (clk_en && !arb_lost && !rec_engaged) || rec_run;
  assign master_sda_pull = tx_active && !tx_bit && !arb_lost && !rec_engaged;
  assign scl_pull        = pace_pull || rec_scl_pull;
  assign sda_pull        = master_sda_pull || rec_sda_pull;

  i2c_scl_pacer #(
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC)
  ) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (pace_run),
    .scl_in    (scl_in),
    .scl_pull  (pace_pull),
    .sample_stb(sample_stb)
  );

  i2c_arb_watch u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_stb(sample_stb),
    .tx_active (tx_active),
    .tx_bit    (tx_bit),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .arb_lost  (arb_lost),
    .loss_evt  (loss_evt),
    .start_seen(start_seen)
  );

  i2c_bus_recover #(
    .LOW_CYC  (LOW_CYC),
    .HIGH_CYC (HIGH_CYC),
    .PULSES   (PULSES),
    .STUCK_CYC(STUCK_CYC)
  ) u_recover (
    .clk        (clk),
    .rst_n      (rst_n),
    .master_idle(!clk_en),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .sample_stb (sample_stb),
    .run_pulses (rec_run),
    .scl_pull   (rec_scl_pull),
    .sda_pull   (rec_sda_pull),
    .busy       (recov_busy),
    .fail       (recov_fail)
  );
endmodule

// File: rtl/i2c_arb_guard_chk.sv
module i2c_arb_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_active,
  input logic tx_bit,
  input logic scl_in,
  input logic sda_in,
  input logic scl_pull,
  input logic sda_pull,
  input logic arb_lost,
  input logic recov_busy,
  input logic recov_fail,
  input logic loss_evt,
  input logic start_seen,
  input logic rec_sda_pull
);
  AST_LOST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && !recov_busy) |-> (!sda_pull && !scl_pull)); // R5

  AST_LOSS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> $past(scl_in && tx_active && tx_bit && !sda_in)); // R4

  AST_LOSS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    loss_evt |=> arb_lost); // R4

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seen && !loss_evt) |=> !arb_lost); // R6

  AST_STOP_SDA_UNDER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_sda_pull) |-> !scl_in); // R9

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    recov_fail |=> recov_fail); // R10

  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    recov_fail |-> (!scl_pull && !sda_pull && !recov_busy)); // R10
endmodule

bind i2c_arb_guard i2c_arb_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_active   (tx_active),
  .tx_bit      (tx_bit),
  .scl_in      (scl_in),
  .sda_in      (sda_in),
  .scl_pull    (scl_pull),
  .sda_pull    (sda_pull),
  .arb_lost    (arb_lost),
  .recov_busy  (recov_busy),
  .recov_fail  (recov_fail),
  .loss_evt    (loss_evt),
  .start_seen  (start_seen),
  .rec_sda_pull(rec_sda_pull)
);

// File: tb/i2c_arb_guard_bench.sv
`timescale 1ns/1ps
module i2c_arb_guard_bench;
  localparam int LOWC  = 4;
  localparam int HIGHC = 4;
  localparam int NPUL  = 9;
  localparam int STUCK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en = 1'b0;
  logic tx_active = 1'b0;
  logic tx_bit = 1'b1;
  logic oth_scl = 1'b0;   // other device pulls SCL low
  logic oth_sda = 1'b0;   // other device pulls SDA low
  logic scl_in, sda_in;
  logic scl_pull, sda_pull, arb_lost, recov_busy, recov_fail;

  // wired-AND bus
  assign scl_in = !(scl_pull || oth_scl);
  assign sda_in = !(sda_pull || oth_sda);

  int n_chk  = 0;
  int n_fail = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, prev_pull = 1'b0;

  always #2 clk = ~clk;

  i2c_arb_guard #(
    .LOW_CYC(LOWC), .HIGH_CYC(HIGHC), .PULSES(NPUL), .STUCK_CYC(STUCK)
  ) u_i2c_arb_guard (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tx_active(tx_active),
    .tx_bit(tx_bit), .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull),
    .sda_pull(sda_pull), .arb_lost(arb_lost), .recov_busy(recov_busy),
    .recov_fail(recov_fail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one clock; samples at the falling edge, with per-cycle rules checked
  task automatic tick();
    prev_scl  = scl_in;
    prev_sda  = sda_in;
    prev_pull = scl_pull;
    @(posedge clk);
    @(negedge clk);
    if (rst_n && arb_lost && !recov_busy)
      chk(!sda_pull && !scl_pull, "R5 lines released while lost", int'({scl_pull, sda_pull}), 0);
    if (rst_n && recov_fail)
      chk(!sda_pull && !scl_pull, "R10 lines released after fail", int'({scl_pull, sda_pull}), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; clk_en = 1'b0; tx_active = 1'b0; tx_bit = 1'b1;
    oth_scl = 1'b0; oth_sda = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic run_len(input logic val, output int n);
    n = 0;
    while (scl_pull == val && n < 100) begin
      n++;
      tick();
    end
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 100; i++) begin
      if (scl_pull && !prev_pull) break;
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int n;
    int rises;
    int first_sda;
    bit stop_seen;
    bit got;

    do_reset();
    // R11 reset state
    chk(scl_pull == 0, "R11 scl_pull", scl_pull, 0);
    chk(sda_pull == 0, "R11 sda_pull", sda_pull, 0);
    chk(arb_lost == 0, "R11 arb_lost", arb_lost, 0);
    chk(recov_busy == 0, "R11 recov_busy", recov_busy, 0);
    chk(recov_fail == 0, "R11 recov_fail", recov_fail, 0);

    // R1 free-running clock, two periods
    clk_en = 1'b1;
    wait_rise();
    for (int p = 0; p < 2; p++) begin
      run_len(1'b1, n);
      chk(n == LOWC, "R1 low phase length", n, LOWC);
      run_len(1'b0, n);
      chk(n == HIGHC + 1, "R1 released phase length", n, HIGHC + 1);
    end

    // R2 another device stretches the low phase
    oth_scl = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      tick();
      if (i >= LOWC)
        chk(scl_pull == 0, "R2 no re-pull while held", scl_pull, 0);
    end
    oth_scl = 1'b0;
    tick();
    run_len(1'b0, n);
    chk(n == HIGHC, "R2 high phase after release", n, HIGHC);

    // R3 early low during the high phase
    run_len(1'b1, n);
    tick();
    chk(scl_in == 1 && scl_pull == 0, "R3 in high phase", scl_pull, 0);
    oth_scl = 1'b1;
    tick();
    chk(scl_pull == 1, "R3 local low starts next cycle", scl_pull, 1);
    oth_scl = 1'b0;
    run_len(1'b1, n);
    chk(n == LOWC, "R3 synced low phase length", n, LOWC);

    // R4 / R12 non-losing cases
    tx_active = 1'b1; tx_bit = 1'b1; oth_sda = 1'b0;
    repeat (20) tick();
    chk(arb_lost == 0, "R4 no loss when SDA agrees", arb_lost, 0);
    chk(sda_pull == 0, "R12 sending one releases SDA", sda_pull, 0);
    tx_bit = 1'b0;
    tick();
    chk(sda_pull == 1, "R12 sending zero pulls SDA", sda_pull, 1);
    oth_sda = 1'b1;
    repeat (20) tick();
    chk(arb_lost == 0, "R4 no loss when sending zero", arb_lost, 0);
    chk(recov_busy == 0, "R7 no recovery with clock enabled", recov_busy, 0);
    tx_active = 1'b0; tx_bit = 1'b1;
    tick();
    chk(sda_pull == 0, "R12 idle master releases SDA", sda_pull, 0);
    repeat (20) tick();
    chk(arb_lost == 0, "R4 no loss when not sending", arb_lost, 0);

    // R4 loss detection
    tx_active = 1'b1;
    got = 1'b0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (arb_lost) begin got = 1'b1; break; end
    end
    chk(got, "R4 loss raised", int'(got), 1);
    chk(prev_scl == 1, "R4 loss taken on SCL high", prev_scl, 1);
    tx_bit = 1'b0;
    repeat (20) tick();
    chk(!scl_pull && !sda_pull, "R5 released after loss", int'({scl_pull, sda_pull}), 0);

    // R6 stop keeps the flag, start clears it
    oth_sda = 1'b0;
    repeat (3) tick();
    chk(arb_lost == 1, "R6 stop does not clear", arb_lost, 1);
    oth_sda = 1'b1;
    tick();
    chk(arb_lost == 0, "R6 start clears", arb_lost, 0);
    tx_active = 1'b0; clk_en = 1'b0; oth_sda = 1'b0;
    repeat (5) tick();

    // R7 stuck detection with an interruption
    do_reset();
    oth_sda = 1'b1;
    repeat (STUCK - 1) tick();
    chk(recov_busy == 0, "R7 first window short", recov_busy, 0);
    oth_sda = 1'b0;
    tick();
    oth_sda = 1'b1;
    repeat (STUCK - 1) tick();
    chk(recov_busy == 0, "R7 count restarted", recov_busy, 0);
    tick();
    chk(recov_busy == 1, "R7 recovery starts", recov_busy, 1);

    // R8 / R9 recovery that frees the line on pulse three
    rises = 0; first_sda = -1; stop_seen = 1'b0;
    for (int i = 0; i < 400; i++) begin
      tick();
      if (scl_pull && !prev_pull) begin
        rises++;
        if (rises == 3) oth_sda = 1'b0;
      end
      if (sda_pull && first_sda < 0) first_sda = rises;
      if (prev_scl && scl_in && !prev_sda && sda_in) stop_seen = 1'b1;
      if (!recov_busy) break;
    end
    chk(rises == 4, "R8 pulses plus stop low", rises, 4);
    chk(first_sda == 4, "R8 SDA untouched during pulses", first_sda, 4);
    chk(stop_seen, "R9 stop condition on bus", int'(stop_seen), 1);
    chk(recov_busy == 0 && recov_fail == 0, "R9 recovery finished", recov_fail, 0);
    chk(!scl_pull && !sda_pull, "R9 lines released", int'({scl_pull, sda_pull}), 0);

    // R10 recovery exhausts its pulses
    do_reset();
    oth_sda = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (recov_busy) break;
      tick();
    end
    rises = 0; first_sda = -1;
    for (int i = 0; i < 400; i++) begin
      tick();
      if (scl_pull && !prev_pull) rises++;
      if (sda_pull && first_sda < 0) first_sda = rises;
      if (!recov_busy) break;
    end
    chk(rises == NPUL, "R10 pulse count", rises, NPUL);
    chk(first_sda == -1, "R8 SDA never driven", first_sda, -1);
    chk(recov_fail == 1, "R10 fail raised", recov_fail, 1);
    oth_sda = 1'b0; clk_en = 1'b1;
    repeat (30) tick();
    chk(recov_fail == 1, "R10 fail sticky", recov_fail, 1);
    chk(scl_pull == 0, "R10 clock held off", scl_pull, 0);

    finish_run();
  end
endmodule